// File: doc/BRIEF.md
# Prefixed Load/Store Decoder with Address Generation

This block takes a 64-bit prefixed instruction, given as a 32-bit prefix word and a 32-bit suffix word, and turns it into a load/store micro-operation. In the same cycle it computes the 64-bit effective address. The caller presents both words, the address of the instruction, and the base register value already read for the base field, together with a valid strobe. One clock later the block shows whether the instruction is a load/store it recognises. When it is, the block also gives the direction, the access size in bytes, whether the loaded value is sign-extended, the data and base register numbers, and the effective address.

The displacement is 34 bits wide and is assembled from both words. A single flag in the prefix selects between addressing relative to the instruction address and addressing from a base register. When that flag is set, the base field must be zero, and any other value is rejected. Only the two load/store prefix classes are decoded here. Register-to-register prefix classes, alignment checks and memory access belong to other blocks.

Top module: `pls_decode_agu`

## Requirements
- R1: While reset is high at a clock edge, every output is cleared to zero after that edge.
- R2: `out_vld` equals `in_vld` delayed by one clock. When `in_vld` is low, all other outputs keep their values.
- R3: An instruction is recognised only when prefix bits 31:26 equal 1 and prefix bits 25:24 are 00 or 10. Prefix classes 01 and 11 are never recognised.
- R4: In class 00, suffix opcode (bits 31:26) 41 decodes as a 4-byte sign-extending load, 56 as a 16-byte load, 57 as an 8-byte load, 60 as a 16-byte store and 61 as an 8-byte store. `out_store` is 1 for a store and 0 for a load, and `out_size` is the size in bytes.
- R5: In class 10, suffix opcode 34 decodes as a 1-byte load, 40 as a 2-byte load, 42 as a 2-byte sign-extending load, 32 as a 4-byte load, 38 as a 1-byte store, 44 as a 2-byte store and 36 as a 4-byte store.
- R6: When an instruction is not recognised, `out_hit` is 0 and `out_store`, `out_size`, `out_sext`, `out_rt`, `out_ra` and `out_ea` are all 0.
- R7: The displacement is prefix bits 17:0 placed above suffix bits 15:0, sign-extended from its bit 33 to 64 bits.
- R8: With prefix bit 20 (the relative flag) at 0, the effective address is base plus displacement when suffix bits 20:16 are nonzero, and the displacement alone when they are zero. With the flag at 1 and that field zero, the effective address is the instruction address plus the displacement.
- R9: With the relative flag at 1 and a nonzero base field, the instruction is not recognised.
- R10: Address sums wrap modulo 2^64.
- R11: `out_sext` is never 1 together with `out_store`.
- R12: On a recognised instruction, `out_rt` is suffix bits 25:21 and `out_ra` is suffix bits 20:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Instruction words are valid this cycle |
| pfx_word | input | 32 | Prefix word |
| sfx_word | input | 32 | Suffix word |
| insn_addr | input | 64 | Address of the prefixed instruction |
| base_val | input | 64 | Value of the register named by the base field |
| out_vld | output | 1 | A decode result was produced this cycle |
| out_hit | output | 1 | Recognised prefixed load/store |
| out_store | output | 1 | 1 for store, 0 for load |
| out_size | output | 5 | Access size in bytes (1, 2, 4, 8 or 16) |
| out_sext | output | 1 | Loaded value is sign-extended |
| out_rt | output | 5 | Data register number |
| out_ra | output | 5 | Base register number |
| out_ea | output | 64 | Effective address |

## Verification
The assertions assume that `in_vld` and the instruction words are known, driven values on every clock edge outside reset. They make no assumption about the encoding, so any opcode, class or flag combination may arrive. Every input is driven at the falling clock edge from reset onward, and `in_vld` is low whenever the bench does not present an instruction. The stimulus therefore deliberately feeds unlisted opcodes, foreign classes and the rejected relative-plus-base combination through the same path as the legal ones.

// File: rtl/pls_pkg.sv
package pls_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned REG_W    = 5;
  localparam int unsigned OPC_W    = 6;
  localparam int unsigned SIZE_W   = 5;
  localparam int unsigned DHI_W    = 18;
  localparam int unsigned DLO_W    = 16;
  localparam int unsigned DISP_W   = DHI_W + DLO_W;
  localparam logic [OPC_W-1:0] PFX_PRIMARY = 6'd1;

  typedef enum logic [1:0] {
    PK_EIGHT_LS = 2'b00,
    PK_RR_A     = 2'b01,
    PK_MOD_LS   = 2'b10,
    PK_RR_B     = 2'b11
  } pfx_kind_e;

  typedef struct packed {
    logic              hit;
    logic              store;
    logic [SIZE_W-1:0] size;
    logic              sext;
  } lsop_t;

  localparam lsop_t LSOP_NONE = '{hit: 1'b0, store: 1'b0, size: '0, sext: 1'b0};

endpackage

// File: rtl/pls_field_split.sv
module pls_field_split
  import pls_pkg::*;
(
  input  logic [WORD_W-1:0] pfx,
  input  logic [WORD_W-1:0] sfx,
  output logic [OPC_W-1:0]  prim_opc,
  output pfx_kind_e         kind,
  output logic              rel,
  output logic [OPC_W-1:0]  sub_opc,
  output logic [REG_W-1:0]  rt,
  output logic [REG_W-1:0]  ra,
  output logic [DISP_W-1:0] disp
);

  localparam int unsigned OPC_LSB  = WORD_W - OPC_W;
  localparam int unsigned KIND_LSB = OPC_LSB - 2;
  localparam int unsigned REL_BIT  = 20;
  localparam int unsigned RT_LSB   = OPC_LSB - REG_W;
  localparam int unsigned RA_LSB   = RT_LSB - REG_W;

  assign prim_opc = pfx[WORD_W-1:OPC_LSB];
  assign kind     = pfx_kind_e'(pfx[KIND_LSB+1:KIND_LSB]);
  assign rel      = pfx[REL_BIT];
  assign sub_opc  = sfx[WORD_W-1:OPC_LSB];
  assign rt       = sfx[RT_LSB+REG_W-1:RT_LSB];
  assign ra       = sfx[RA_LSB+REG_W-1:RA_LSB];
  assign disp     = {pfx[DHI_W-1:0], sfx[DLO_W-1:0]};

  logic unused_pfx_bits;
  assign unused_pfx_bits = ^{pfx[KIND_LSB-1:REL_BIT+1], pfx[REL_BIT-1:DHI_W]};

endmodule

// File: rtl/pls_op_table.sv
module pls_op_table
  import pls_pkg::*;
(
  input  pfx_kind_e        kind,
  input  logic [OPC_W-1:0] sub_opc,
  output lsop_t            op
);

  function automatic lsop_t mk(input logic st, input int unsigned bytes, input logic sx);
    lsop_t r;
    r.hit   = 1'b1;
    r.store = st;
    r.size  = SIZE_W'(bytes);
    r.sext  = sx;
    return r;
  endfunction

  lsop_t eight_op;
  lsop_t mod_op;

  always_comb begin
    case (sub_opc)
      6'd41:   eight_op = mk(1'b0, 4,  1'b1);
      6'd56:   eight_op = mk(1'b0, 16, 1'b0);
      6'd57:   eight_op = mk(1'b0, 8,  1'b0);
      6'd60:   eight_op = mk(1'b1, 16, 1'b0);
      6'd61:   eight_op = mk(1'b1, 8,  1'b0);
      default: eight_op = LSOP_NONE;
    endcase
  end

  always_comb begin
    case (sub_opc)
      6'd32:   mod_op = mk(1'b0, 4, 1'b0);
      6'd34:   mod_op = mk(1'b0, 1, 1'b0);
      6'd36:   mod_op = mk(1'b1, 4, 1'b0);
      6'd38:   mod_op = mk(1'b1, 1, 1'b0);
      6'd40:   mod_op = mk(1'b0, 2, 1'b0);
      6'd42:   mod_op = mk(1'b0, 2, 1'b1);
      6'd44:   mod_op = mk(1'b1, 2, 1'b0);
      default: mod_op = LSOP_NONE;
    endcase
  end

  always_comb begin
    case (kind)
      PK_EIGHT_LS: op = eight_op;
      PK_MOD_LS:   op = mod_op;
      default:     op = LSOP_NONE;
    endcase
  end

endmodule

// File: rtl/pls_agu.sv
module pls_agu
  import pls_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              rel,
  input  logic [REG_W-1:0]  ra,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic              form_ok,
  output logic [ADDR_W-1:0] ea
);

  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic              ra_zero;
  logic [ADDR_W-1:0] disp_x;
  logic [ADDR_W-1:0] addend;

  assign ra_zero = (ra == '0);
  assign disp_x  = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign form_ok = !(rel && !ra_zero);

  always_comb begin
    if (rel)
      addend = pc;
    else if (!ra_zero)
      addend = base;
    else
      addend = '0;
  end

  assign ea = addend + disp_x;

endmodule

// File: rtl/pls_decode_agu.sv
module pls_decode_agu
  import pls_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic [WORD_W-1:0]    pfx_word,
  input  logic [WORD_W-1:0]    sfx_word,
  input  logic [ADDR_W-1:0]    insn_addr,
  input  logic [ADDR_W-1:0]    base_val,
  output logic                 out_vld,
  output logic                 out_hit,
  output logic                 out_store,
  output logic [SIZE_W-1:0]    out_size,
  output logic                 out_sext,
  output logic [REG_W-1:0]     out_rt,
  output logic [REG_W-1:0]     out_ra,
  output logic [ADDR_W-1:0]    out_ea
);

  logic [OPC_W-1:0]  prim_opc;
  pfx_kind_e         kind;
  logic              rel;
  logic [OPC_W-1:0]  sub_opc;
  logic [REG_W-1:0]  rt;
  logic [REG_W-1:0]  ra;
  logic [DISP_W-1:0] disp;
  lsop_t             op;
  logic              form_ok;
  logic [ADDR_W-1:0] ea;
  logic              hit_d;

  pls_field_split u_split (
    .pfx      (pfx_word),
    .sfx      (sfx_word),
    .prim_opc (prim_opc),
    .kind     (kind),
    .rel      (rel),
    .sub_opc  (sub_opc),
    .rt       (rt),
    .ra       (ra),
    .disp     (disp)
  );

  pls_op_table u_table (
    .kind    (kind),
    .sub_opc (sub_opc),
    .op      (op)
  );

  pls_agu #(.ADDR_W(ADDR_W)) u_agu (
    .rel     (rel),
    .ra      (ra),
    .base    (base_val),
    .pc      (insn_addr),
    .disp    (disp),
    .form_ok (form_ok),
    .ea      (ea)
  );

  assign hit_d = (prim_opc == PFX_PRIMARY) && op.hit && form_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_hit   <= 1'b0;
      out_store <= 1'b0;
      out_size  <= '0;
      out_sext  <= 1'b0;
      out_rt    <= '0;
      out_ra    <= '0;
      out_ea    <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_hit   <= hit_d;
        out_store <= hit_d & op.store;
        out_size  <= hit_d ? op.size : '0;
        out_sext  <= hit_d & op.sext;
        out_rt    <= hit_d ? rt : '0;
        out_ra    <= hit_d ? ra : '0;
        out_ea    <= hit_d ? ea : '0;
      end
    end
  end

endmodule

// File: rtl/pls_decode_agu_chk.sv
module pls_decode_agu_chk
  import pls_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [WORD_W-1:0] pfx_word,
  input logic [WORD_W-1:0] sfx_word,
  input logic              out_vld,
  input logic              out_hit,
  input logic              out_store,
  input logic [SIZE_W-1:0] out_size,
  input logic              out_sext,
  input logic [REG_W-1:0]  out_rt,
  input logic [REG_W-1:0]  out_ra,
  input logic [ADDR_W-1:0] out_ea
);

  // R2: valid strobe is delayed by exactly one clock
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  a_r2_vld_drops: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);

  // R2: results hold without a strobe
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(out_hit) && $stable(out_ea) && $stable(out_size)
                 && $stable(out_store) && $stable(out_rt) && $stable(out_ra)));

  // R3: wrong primary opcode or register-to-register class is never recognised
  a_r3_primary: assert property (@(posedge clk) disable iff (rst)
    (in_vld && pfx_word[31:26] != 6'd1) |=> !out_hit);
  a_r3_rr_class: assert property (@(posedge clk) disable iff (rst)
    (in_vld && pfx_word[24]) |=> !out_hit);

  // R6: a miss drives every other field to zero
  a_r6_miss_zero: assert property (@(posedge clk) disable iff (rst)
    !out_hit |-> (!out_store && out_size == '0 && !out_sext
                  && out_rt == '0 && out_ra == '0 && out_ea == '0));

  // R9: relative flag with nonzero base field is rejected
  a_r9_bad_form: assert property (@(posedge clk) disable iff (rst)
    (in_vld && pfx_word[20] && sfx_word[20:16] != 5'd0) |=> !out_hit);

  // R11: stores never carry the sign-extend flag
  a_r11_no_sext_store: assert property (@(posedge clk) disable iff (rst)
    out_store |-> !out_sext);

  // R12: a hit carries a single power-of-two size and the suffix register fields
  a_r12_size_onehot: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> ($countones(out_size) == 1));
  a_r12_fields: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !rst) |=> (!out_hit || (out_rt == $past(sfx_word[25:21])
                                        && out_ra == $past(sfx_word[20:16]))));

endmodule

bind pls_decode_agu pls_decode_agu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_vld    (in_vld),
  .pfx_word  (pfx_word),
  .sfx_word  (sfx_word),
  .out_vld   (out_vld),
  .out_hit   (out_hit),
  .out_store (out_store),
  .out_size  (out_size),
  .out_sext  (out_sext),
  .out_rt    (out_rt),
  .out_ra    (out_ra),
  .out_ea    (out_ea)
);

// File: tb/sim_pls_decode_agu.sv
module sim_pls_decode_agu;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int NVEC       = 17;

  // entry: [21:20] class, [19] rel, [18:13] sub opcode, [12:8] base field,
  //        [7] hit, [6] store, [5:1] size, [0] sext
  localparam logic [21:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 6'd41, 5'd3,  1'b1, 1'b0, 5'd4,  1'b1},
    {2'd0, 1'b0, 6'd56, 5'd0,  1'b1, 1'b0, 5'd16, 1'b0},
    {2'd0, 1'b1, 6'd57, 5'd0,  1'b1, 1'b0, 5'd8,  1'b0},
    {2'd0, 1'b0, 6'd60, 5'd7,  1'b1, 1'b1, 5'd16, 1'b0},
    {2'd0, 1'b0, 6'd61, 5'd31, 1'b1, 1'b1, 5'd8,  1'b0},
    {2'd2, 1'b0, 6'd32, 5'd1,  1'b1, 1'b0, 5'd4,  1'b0},
    {2'd2, 1'b1, 6'd34, 5'd0,  1'b1, 1'b0, 5'd1,  1'b0},
    {2'd2, 1'b0, 6'd36, 5'd2,  1'b1, 1'b1, 5'd4,  1'b0},
    {2'd2, 1'b0, 6'd38, 5'd0,  1'b1, 1'b1, 5'd1,  1'b0},
    {2'd2, 1'b0, 6'd40, 5'd4,  1'b1, 1'b0, 5'd2,  1'b0},
    {2'd2, 1'b0, 6'd42, 5'd5,  1'b1, 1'b0, 5'd2,  1'b1},
    {2'd2, 1'b1, 6'd44, 5'd0,  1'b1, 1'b1, 5'd2,  1'b0},
    {2'd0, 1'b0, 6'd32, 5'd1,  1'b0, 1'b0, 5'd0,  1'b0},
    {2'd2, 1'b0, 6'd41, 5'd1,  1'b0, 1'b0, 5'd0,  1'b0},
    {2'd1, 1'b0, 6'd32, 5'd1,  1'b0, 1'b0, 5'd0,  1'b0},
    {2'd3, 1'b0, 6'd41, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0},
    {2'd2, 1'b1, 6'd32, 5'd3,  1'b0, 1'b0, 5'd0,  1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [31:0] pfx_word = '0;
  logic [31:0] sfx_word = '0;
  logic [63:0] insn_addr = '0;
  logic [63:0] base_val = '0;
  logic        out_vld, out_hit, out_store, out_sext;
  logic [4:0]  out_size, out_rt, out_ra;
  logic [63:0] out_ea;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pls_decode_agu u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .pfx_word(pfx_word), .sfx_word(sfx_word),
    .insn_addr(insn_addr), .base_val(base_val), .out_vld(out_vld), .out_hit(out_hit),
    .out_store(out_store), .out_size(out_size), .out_sext(out_sext), .out_rt(out_rt),
    .out_ra(out_ra), .out_ea(out_ea)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_pfx(input logic [5:0] prim, input logic [1:0] cls,
                                         input logic rel, input logic [33:0] d);
    return {prim, cls, 3'b000, rel, 2'b00, d[33:16]};
  endfunction

  function automatic logic [31:0] mk_sfx(input logic [5:0] opc, input logic [4:0] rt,
                                         input logic [4:0] ra, input logic [33:0] d);
    return {opc, rt, ra, d[15:0]};
  endfunction

  // independent address model from R7, R8, R10
  function automatic logic [63:0] want_ea(input logic rel, input logic [4:0] ra, input logic [33:0] d,
                                          input logic [63:0] pc, input logic [63:0] base);
    logic [63:0] dx;
    dx = {{30{d[33]}}, d};
    if (rel)            return pc + dx;
    else if (ra != 5'd0) return base + dx;
    else                return dx;
  endfunction

  task automatic issue(input logic [31:0] p, input logic [31:0] s,
                       input logic [63:0] pc, input logic [63:0] b);
    @(negedge clk);
    pfx_word = p; sfx_word = s; insn_addr = pc; base_val = b; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] held_ea;
    logic [33:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk(!out_vld && !out_hit && out_ea == 64'd0 && out_size == 5'd0, "R1 reset state",
        {out_vld, out_hit, out_size}, 64'd0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [21:0] v;
      logic [33:0] dv;
      logic [4:0]  rt;
      logic [63:0] pc, base, exp_ea;
      string       tag;
      v    = VEC[i];
      dv   = (i % 2 == 1) ? 34'(i * 4096 + 5) : (34'h3_FFFF_FFFF - 34'(i * 256 + 2));
      rt   = 5'(i + 9);
      pc   = 64'h0000_0000_4000_0100 + 64'(i * 8);
      base = 64'h0000_1000_0000_0000 + 64'(i);
      issue(mk_pfx(6'd1, v[21:20], v[19], dv), mk_sfx(v[18:13], rt, v[12:8], dv), pc, base);
      if (v[21:20] == 2'd1 || v[21:20] == 2'd3) tag = "R3";
      else if (v[19] && v[12:8] != 5'd0)        tag = "R9";
      else if (!v[7])                           tag = "R6";
      else if (v[21:20] == 2'd0)                tag = "R4";
      else                                      tag = "R5";
      chk(out_vld == 1'b1, "R2 valid strobe", {63'd0, out_vld}, 64'd1);
      chk({out_hit, out_store, out_size, out_sext} == v[7:0], tag,
          {56'd0, out_hit, out_store, out_size, out_sext}, {56'd0, v[7:0]});
      exp_ea = v[7] ? want_ea(v[19], v[12:8], dv, pc, base) : 64'd0;
      chk(out_ea == exp_ea, v[19] ? "R8 relative address" : "R8 R7 base address", out_ea, exp_ea);
      chk(out_rt == (v[7] ? rt : 5'd0) && out_ra == (v[7] ? v[12:8] : 5'd0), "R12 register fields",
          {54'd0, out_rt, out_ra}, {54'd0, (v[7] ? rt : 5'd0), (v[7] ? v[12:8] : 5'd0)});
      chk(!(out_store && out_sext), "R11 no sign extend on store", {62'd0, out_store, out_sext}, 64'd0);
    end

    // R2: hold while strobe is low
    d = 34'h0_0000_0040;
    issue(mk_pfx(6'd1, 2'd2, 1'b0, d), mk_sfx(6'd40, 5'd6, 5'd2, d), 64'h100, 64'h2000);
    held_ea = out_ea;
    @(negedge clk);
    pfx_word = mk_pfx(6'd1, 2'd1, 1'b0, 34'd0); sfx_word = '0; base_val = 64'hDEAD;
    repeat (2) @(negedge clk);
    chk(out_ea == held_ea && out_hit && out_size == 5'd2 && !out_vld, "R2 hold", out_ea, held_ea);

    // R3: wrong primary opcode
    issue(mk_pfx(6'd2, 2'd2, 1'b0, d), mk_sfx(6'd32, 5'd6, 5'd2, d), 64'h100, 64'h2000);
    chk(!out_hit && out_ea == 64'd0, "R3 primary opcode", {63'd0, out_hit}, 64'd0);

    // R10: base wrap
    d = 34'h0_0000_0200;
    issue(mk_pfx(6'd1, 2'd0, 1'b0, d), mk_sfx(6'd57, 5'd1, 5'd4, d), 64'h0, 64'hFFFF_FFFF_FFFF_FF00);
    chk(out_ea == 64'h0000_0000_0000_0100, "R10 base wrap", out_ea, 64'h100);

    // R10: relative wrap with negative displacement
    d = 34'h3_FFFF_FFE0;
    issue(mk_pfx(6'd1, 2'd2, 1'b1, d), mk_sfx(6'd34, 5'd1, 5'd0, d), 64'h10, 64'h0);
    chk(out_ea == 64'hFFFF_FFFF_FFFF_FFF0, "R10 relative wrap", out_ea, 64'hFFFF_FFFF_FFFF_FFF0);

    // R7: most negative displacement, absolute form
    d = 34'h2_0000_0000;
    issue(mk_pfx(6'd1, 2'd2, 1'b0, d), mk_sfx(6'd38, 5'd1, 5'd0, d), 64'h5555, 64'h7777);
    chk(out_ea == 64'hFFFF_FFFE_0000_0000, "R7 sign extension", out_ea, 64'hFFFF_FFFE_0000_0000);

    // R7: largest positive displacement
    d = 34'h1_FFFF_FFFF;
    issue(mk_pfx(6'd1, 2'd0, 1'b0, d), mk_sfx(6'd61, 5'd1, 5'd0, d), 64'h0, 64'h0);
    chk(out_ea == 64'h0000_0001_FFFF_FFFF, "R7 positive extreme", out_ea, 64'h0000_0001_FFFF_FFFF);

    // R1: reset clears live results
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!out_vld && !out_hit && !out_store && out_size == 5'd0 && out_ea == 64'd0
        && out_rt == 5'd0 && out_ra == 5'd0, "R1 reset clears", out_ea, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule